// File: doc/BRIEF.md
# Systolic Matrix Multiply Array

This block is a square grid of multiply-accumulate cells that forms products of an activation stream with a stationary weight matrix. The grid is `N` by `N`, with a default of 2. Every data word is a signed 16-bit fixed-point number with eight fraction bits. Activation lane `r` enters cell `(r,0)` on the west edge and moves one cell east each clock. Partial sums start at zero above the top row. Each sum moves one cell south each clock and gains that cell's product on the way. Column results leave at the south edge. All arithmetic saturates to the 16-bit signed range.

Weights are double-buffered. While the grid computes with its active weights, a new matrix can be shifted down through a second set of registers, one row per shift cycle. A single-cycle swap pulse then copies the staged weights into the active registers of every cell at once. To multiply a batch of vectors, the feeder presents lane `r` of vector `t` one cycle after lane `r-1`. This skew is its job. Each activation word carries a valid bit. An invalid lane contributes nothing.

The block has no back-pressure. There is no ready signal, because a systolic grid cannot stall one lane without breaking the skew. The feeder may issue a new skewed vector on every cycle. The consumer must take each column result in the cycle its valid is high.

Top module: `sysmm_array`

## Requirements
- R1: While `rst` is high, and after it is released, all registers are zero: `psum_out` and `psum_vld` read zero, and both active and staged weights are zero.
- R2: If lane 0 of a vector is captured at clock edge E, and lane r at edge E+r, then the column c result is on `psum_out` after edge E+N-1+c and stays until the next edge.
- R3: Each cycle with `wgt_shift` high moves every staged weight one row down, and row 0 takes `wgt_in` lane c (bits c*16 and up). After N shifts, row r holds the word fed on shift number N-1-r (counting from 0).
- R4: A `wgt_swap` pulse copies the staged weight into the active weight of every cell. Shifting without a swap leaves the results unchanged. When swap and shift occur together, the active weight takes the staged value from before the shift.
- R5: Column c result = s after rows 0..N-1 in order, where s starts at 0 and s = add(s, mul(x_r, W[r][c])) for every valid lane r.
- R6: mul(a,b) forms the 32-bit signed product, shifts it arithmetically right by 8 (rounding toward minus infinity), and clamps it to [-32768, 32767].
- R7: add(a,b) is the exact signed sum clamped to [-32768, 32767]; it never wraps.
- R8: A lane whose valid is low adds nothing; its activation value has no effect on any result.
- R9: `psum_vld[c]` is high exactly when at least one lane of that vector was valid; when it is low, `psum_out` lane c reads zero.
- R10: Vectors may be issued on consecutive cycles; every vector with a valid lane yields exactly one result per column, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| act_in | input | N*16 | Activation word per row lane, lane r in bits r*16 +: 16 |
| act_vld | input | N | Valid bit per activation lane |
| wgt_in | input | N*16 | Weight word per column entering the top row |
| wgt_shift | input | 1 | Shift staged weights one row down |
| wgt_swap | input | 1 | Copy staged weights to active weights in all cells |
| psum_out | output | N*16 | Column results, lane c in bits c*16 +: 16 |
| psum_vld | output | N | Result valid per column |

## Verification
If a cell holds a wrong active weight, or one in the wrong row, every later valid vector gives a wrong result in that cell's column. The error shows N-1+c cycles after the vector's first lane enters. If an activation or valid register is dropped or doubled, the results appear in the wrong cycle or under the wrong valid, and the per-column order check catches this on the first vector. If saturation is wrong, the error shows only for operands near the range limits, so directed full-scale and sign-boundary vectors are sent next to the random ones.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int SA_DIM  = 2;
  localparam int SA_DW   = 16;
  localparam int SA_FRAC = 8;
endpackage

// File: rtl/sa_mac.sv
module sa_mac #(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] w,
  input  logic [W-1:0] acc,
  input  logic         en,
  output logic [W-1:0] mul,
  output logic [W-1:0] sum
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] MAXP = PW'((64'sd1 <<< (W-1)) - 64'sd1);
  localparam logic signed [PW-1:0] MINP = ~MAXP;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] prod_sh;
  logic signed [W:0]    ext;
  logic [W-1:0]         sat;

  always_comb begin
    prod    = PW'($signed(a)) * PW'($signed(w));
    prod_sh = prod >>> FRAC;
    if (prod_sh > MAXP)      mul = MAXP[W-1:0];
    else if (prod_sh < MINP) mul = MINP[W-1:0];
    else                     mul = prod_sh[W-1:0];
    ext = {acc[W-1], acc} + {mul[W-1], mul};
    if (ext[W] != ext[W-1]) sat = ext[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else                    sat = ext[W-1:0];
    sum = en ? sat : acc;
  end
endmodule

// File: rtl/sa_cell.sv
module sa_cell #(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] act_i,
  input  logic         vld_i,
  input  logic         pv_i,
  input  logic [W-1:0] psum_i,
  input  logic [W-1:0] wsh_i,
  input  logic         shift,
  input  logic         swap,
  output logic [W-1:0] act_o,
  output logic         vld_o,
  output logic         pv_o,
  output logic [W-1:0] psum_o,
  output logic [W-1:0] wsh_o
);
  logic [W-1:0] wact;
  logic [W-1:0] mul;
  logic [W-1:0] sum;

  sa_mac #(.W(W), .FRAC(FRAC)) u_mac (
    .a(act_i), .w(wact), .acc(psum_i), .en(vld_i), .mul(mul), .sum(sum)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      act_o  <= '0;
      vld_o  <= 1'b0;
      pv_o   <= 1'b0;
      psum_o <= '0;
      wsh_o  <= '0;
      wact   <= '0;
    end else begin
      act_o  <= act_i;
      vld_o  <= vld_i;
      pv_o   <= pv_i | vld_i;
      psum_o <= sum;
      if (shift) wsh_o <= wsh_i;
      if (swap)  wact  <= wsh_o;
    end
  end

  // R2: activation and its valid hop one cell per cycle
  p_act_hop_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (act_o == $past(act_i)) && (vld_o == $past(vld_i)));

  // R3: staged weight moves only on shift
  p_shift_move_r3: assert property (@(posedge clk) disable iff (rst)
    shift |=> wsh_o == $past(wsh_i));
  p_shift_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(wsh_o));

  // R4: active weight changes only on a swap pulse
  p_wact_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !swap |=> $stable(wact));

  // R8: an invalid lane passes the sum from above unchanged
  p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> psum_o == $past(psum_i));

  // R6: product of same-sign nonzero operands is never negative
  p_mul_sign_r6: assert property (@(posedge clk) disable iff (rst)
    (act_i != '0 && wact != '0 && act_i[W-1] == wact[W-1]) |-> !mul[W-1]);

  // R7: saturating add never wraps across sign
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !psum_i[W-1] && !mul[W-1]) |-> !sum[W-1]);
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (vld_i && psum_i[W-1] && mul[W-1]) |-> sum[W-1]);
endmodule

// File: rtl/sysmm_array.sv
module sysmm_array
  import sa_pkg::*;
#(
  parameter int N    = SA_DIM,
  parameter int W    = SA_DW,
  parameter int FRAC = SA_FRAC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N*W-1:0] act_in,
  input  logic [N-1:0]   act_vld,
  input  logic [N*W-1:0] wgt_in,
  input  logic           wgt_shift,
  input  logic           wgt_swap,
  output logic [N*W-1:0] psum_out,
  output logic [N-1:0]   psum_vld
);
  logic [W-1:0] act_h [N][N+1];
  logic         vld_h [N][N+1];
  logic [W-1:0] ps_v  [N+1][N];
  logic         pv_v  [N+1][N];
  logic [W-1:0] wsh_v [N+1][N];

  for (genvar r = 0; r < N; r++) begin : g_west
    assign act_h[r][0] = act_in[r*W +: W];
    assign vld_h[r][0] = act_vld[r];
    logic east_unused;
    assign east_unused = ^{vld_h[r][N], act_h[r][N]};
  end

  for (genvar c = 0; c < N; c++) begin : g_edge
    assign ps_v[0][c]  = '0;
    assign pv_v[0][c]  = 1'b0;
    assign wsh_v[0][c] = wgt_in[c*W +: W];
    assign psum_out[c*W +: W] = ps_v[N][c];
    assign psum_vld[c] = pv_v[N][c];
    logic south_unused;
    assign south_unused = ^wsh_v[N][c];

    // R9: an idle column carries zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
      !psum_vld[c] |-> psum_out[c*W +: W] == '0);
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      sa_cell #(.W(W), .FRAC(FRAC)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .act_i (act_h[r][c]),
        .vld_i (vld_h[r][c]),
        .pv_i  (pv_v[r][c]),
        .psum_i(ps_v[r][c]),
        .wsh_i (wsh_v[r][c]),
        .shift (wgt_shift),
        .swap  (wgt_swap),
        .act_o (act_h[r][c+1]),
        .vld_o (vld_h[r][c+1]),
        .pv_o  (pv_v[r+1][c]),
        .psum_o(ps_v[r+1][c]),
        .wsh_o (wsh_v[r+1][c])
      );
    end
  end
endmodule

// File: tb/test_sysmm_array.sv
`timescale 1ns/1ps
module test_sysmm_array;
  localparam int N = 2;
  localparam int W = 16;
  localparam int MAXV = 32;
  localparam int QD = 1024;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N*W-1:0] act_in = '0;
  logic [N-1:0]   act_vld = '0;
  logic [N*W-1:0] wgt_in = '0;
  logic           wgt_shift = 1'b0;
  logic           wgt_swap = 1'b0;
  logic [N*W-1:0] psum_out;
  logic [N-1:0]   psum_vld;

  always #2 clk = ~clk;

  sysmm_array #(.N(N), .W(W), .FRAC(8)) i_sysmm_array (
    .clk(clk), .rst(rst), .act_in(act_in), .act_vld(act_vld),
    .wgt_in(wgt_in), .wgt_shift(wgt_shift), .wgt_swap(wgt_swap),
    .psum_out(psum_out), .psum_vld(psum_vld)
  );

  int ecount = 0;
  always @(posedge clk) ecount <= ecount + 1;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string vtag = "R5";

  logic [15:0] cur_w [N][N];
  logic [15:0] shd_w [N][N];
  logic [15:0] nxt_w [N][N];
  logic [15:0] xv [MAXV][N];
  logic        mv [MAXV][N];
  logic [15:0] eq_val [N][QD];
  int          eq_cyc [N][QD];
  int          wp [N];
  int          rp [N];

  function automatic logic [15:0] ref_mul(logic [15:0] a, logic [15:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    p = p >>> 8;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return p[15:0];
  endfunction

  function automatic logic [15:0] ref_add(logic [15:0] a, logic [15:0] b);
    longint s;
    s = longint'($signed(a)) + longint'($signed(b));
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s[15:0];
  endfunction

  task automatic chk(bit ok, string req, string what, longint actual, longint expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  task automatic monitor();
    for (int c = 0; c < N; c++) begin
      if (psum_vld[c]) begin
        if (rp[c] == wp[c]) begin
          chk(0, "R9", "unexpected valid result", c, -1);
        end else begin
          chk(psum_out[c*W +: W] == eq_val[c][rp[c]], vtag, "column value",
              psum_out[c*W +: W], eq_val[c][rp[c]]);
          chk(ecount == eq_cyc[c][rp[c]], "R2", "result cycle", ecount, eq_cyc[c][rp[c]]);
          rp[c]++;
        end
      end else begin
        chk(psum_out[c*W +: W] == '0, "R9", "idle column value", psum_out[c*W +: W], 0);
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    monitor();
  endtask

  task automatic load_weights();
    for (int k = 0; k < N; k++) begin
      tick();
      wgt_shift = 1'b1;
      for (int c = 0; c < N; c++) wgt_in[c*W +: W] = nxt_w[N-1-k][c];
    end
    tick();
    wgt_shift = 1'b0;
    shd_w = nxt_w;
  endtask

  task automatic do_swap();
    tick();
    wgt_swap = 1'b1;
    tick();
    wgt_swap = 1'b0;
    cur_w = shd_w;
  endtask

  // stream nv skewed vectors; optionally shift nxt_w in at the same time (R4)
  task automatic run_stream(int nv, bit load_next);
    for (int k = 0; k < nv + N - 1; k++) begin
      tick();
      for (int r = 0; r < N; r++) begin
        int t;
        t = k - r;
        if (t >= 0 && t < nv) begin
          act_in[r*W +: W] = xv[t][r];
          act_vld[r] = mv[t][r];
        end else begin
          act_in[r*W +: W] = 16'($urandom);
          act_vld[r] = 1'b0;
        end
      end
      if (k < nv) begin
        bit any;
        any = 0;
        for (int r = 0; r < N; r++) any |= mv[k][r];
        if (any) begin
          for (int c = 0; c < N; c++) begin
            logic [15:0] s;
            s = '0;
            for (int r = 0; r < N; r++)
              if (mv[k][r]) s = ref_add(s, ref_mul(xv[k][r], cur_w[r][c]));
            eq_val[c][wp[c]] = s;
            eq_cyc[c][wp[c]] = ecount + N + c;
            wp[c]++;
          end
        end
      end
      if (load_next && k < N) begin
        wgt_shift = 1'b1;
        for (int c = 0; c < N; c++) wgt_in[c*W +: W] = nxt_w[N-1-k][c];
      end else begin
        wgt_shift = 1'b0;
      end
    end
    tick();
    act_vld = '0;
    wgt_shift = 1'b0;
    if (load_next) shd_w = nxt_w;
    for (int i = 0; i < 2*N + 2; i++) tick();
  endtask

  function automatic logic [15:0] rnd_word();
    if ($urandom_range(0, 3) == 0) return 16'($urandom);
    return 16'($urandom_range(0, 2047)) - 16'd1024;
  endfunction

  task automatic fill_const(int nv, logic [15:0] val);
    for (int t = 0; t < nv; t++)
      for (int r = 0; r < N; r++) begin
        xv[t][r] = val;
        mv[t][r] = 1'b1;
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual %0d expected %0d", ecount, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < N; c++) begin wp[c] = 0; rp[c] = 0; end
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin cur_w[r][c] = '0; shd_w[r][c] = '0; end

    // R1: outputs held at zero during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(psum_out == '0, "R1", "psum_out in reset", psum_out, 0);
      chk(psum_vld == '0, "R1", "psum_vld in reset", psum_vld, 0);
    end
    rst = 1'b0;

    // R1: active weights are zero after reset, so results are zero
    vtag = "R1";
    xv[0][0] = 16'h0100; xv[0][1] = 16'h7fff; mv[0][0] = 1; mv[0][1] = 1;
    xv[1][0] = 16'h8000; xv[1][1] = 16'h0333; mv[1][0] = 1; mv[1][1] = 1;
    run_stream(2, 0);

    // R3 / R5: distinct weights expose row placement and row order
    vtag = "R5";
    nxt_w[0][0] = 16'h0100; nxt_w[0][1] = 16'h0200;
    nxt_w[1][0] = 16'hff00; nxt_w[1][1] = 16'h0080;
    load_weights();
    do_swap();
    xv[0][0] = 16'h0100; xv[0][1] = 16'h0100; mv[0][0] = 1; mv[0][1] = 1;
    xv[1][0] = 16'h0300; xv[1][1] = 16'hfe00; mv[1][0] = 1; mv[1][1] = 1;
    xv[2][0] = 16'h0040; xv[2][1] = 16'h0800; mv[2][0] = 1; mv[2][1] = 1;
    run_stream(3, 0);

    // R8: invalid lanes carry large garbage that must not matter; R9: all-invalid vector
    vtag = "R8";
    xv[0][0] = 16'h7fff; xv[0][1] = 16'h0200; mv[0][0] = 0; mv[0][1] = 1;
    xv[1][0] = 16'h0200; xv[1][1] = 16'h8000; mv[1][0] = 1; mv[1][1] = 0;
    xv[2][0] = 16'h7abc; xv[2][1] = 16'h9876; mv[2][0] = 0; mv[2][1] = 0;
    xv[3][0] = 16'h0100; xv[3][1] = 16'h0100; mv[3][0] = 1; mv[3][1] = 1;
    run_stream(4, 0);

    // R6 / R7: full-scale positive and negative saturation
    vtag = "R6";
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) nxt_w[r][c] = 16'h7fff;
    load_weights();
    do_swap();
    fill_const(2, 16'h7fff);
    run_stream(2, 0);
    vtag = "R7";
    fill_const(2, 16'h8000);
    run_stream(2, 0);

    // R6: rounding toward minus infinity
    vtag = "R6";
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) nxt_w[r][c] = 16'h0001;
    load_weights();
    do_swap();
    fill_const(3, 16'hffff);
    run_stream(3, 0);

    // R4: shift new weights during a stream, results keep old weights until swap
    vtag = "R4";
    nxt_w[0][0] = 16'h0180; nxt_w[0][1] = 16'hfe80;
    nxt_w[1][0] = 16'h0040; nxt_w[1][1] = 16'h0300;
    for (int t = 0; t < 6; t++)
      for (int r = 0; r < N; r++) begin xv[t][r] = rnd_word(); mv[t][r] = 1'b1; end
    run_stream(6, 1);
    do_swap();
    run_stream(6, 0);

    // R10 / R5: random back-to-back streams with mixed lane validity
    vtag = "R5";
    for (int round = 0; round < 24; round++) begin
      int nv;
      nv = $urandom_range(N, 16);
      for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) nxt_w[r][c] = rnd_word();
      for (int t = 0; t < nv; t++)
        for (int r = 0; r < N; r++) begin
          xv[t][r] = rnd_word();
          mv[t][r] = ($urandom_range(0, 3) != 0);
        end
      if (round[0]) begin
        run_stream(nv, 1);
        do_swap();
      end else begin
        run_stream(nv, 0);
        load_weights();
        do_swap();
      end
    end

    for (int i = 0; i < 2*N + 4; i++) tick();
    // R10: every issued vector with a valid lane produced exactly one result per column
    for (int c = 0; c < N; c++)
      chk(rp[c] == wp[c], "R10", "results consumed", rp[c], wp[c]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule